// File: doc/BRIEF.md
# CPU Power Mode Controller

This block decides which operating state the processor core is in and drives the clock and oscillator enables that go with each state. The states are reset, exception entry, normal execution, a light sleep, a deep standby and bus release. A single-cycle strobe from the core's sleep instruction moves execution into one of the two low-power states. A control bit picks which one. The light state stops only the core clock. The deep state also stops the peripheral clocks and the oscillator.

Each low-power state has its own set of wake events. Every wakeup goes through exception entry before execution resumes. When the deep state is left, the oscillator restarts. A programmable stabilization count, timed on the free-running reference clock, must then run out before any clock enable comes back. A bus request from another master parks the core in bus release and grants the bus. When the request is withdrawn, the core returns to the state it left.

Top module: `cpu_pwr_ctrl`

## Requirements
- R1: While `por_n` is low, `state_o` reads 0 (RESET). The encoding of `state_o` is RESET=0, EXCEPTION=1, EXECUTE=2, SLEEP=3, STANDBY=4, BUSREL=5. At the first edge where RESET sees `rst_req` low and no stabilization count is running, the state becomes EXCEPTION. At the edge where EXCEPTION sees `exc_done` high, the state becomes EXECUTE.
- R2: In EXECUTE, `sleep_stb` with `stby_sel`=0 moves the block to SLEEP. In SLEEP, `cpu_clk_en`=0 while `per_clk_en`=1 and `osc_en`=1.
- R3: In EXECUTE, `sleep_stb` with `stby_sel`=1 moves the block to STANDBY. In STANDBY, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R4: In SLEEP, any of `irq`, `nmi` or `dma_aerr` moves the block to EXCEPTION at the next edge. `rst_req` moves it to RESET.
- R5: In STANDBY, `irq`, `dma_aerr` and `bus_req` have no effect. The state stays STANDBY, all enables stay 0 and `bus_gnt` stays 0.
- R6: When STANDBY samples `nmi`, `osc_en` rises after that edge while the state stays STANDBY with the core and peripheral clocks off. The state becomes EXCEPTION at the (W+1)th edge after the sampling edge, where W is `osc_wait`.
- R7: When STANDBY samples `rst_req`, the state becomes RESET with `osc_en`=1. The core and peripheral clock enables stay 0 for W cycles. The state reaches EXCEPTION no earlier than the (W+1)th edge after the sampling edge.
- R8: In EXECUTE or SLEEP, `bus_req` moves the block to BUSREL with `bus_gnt`=1 from the next cycle. After `bus_req` falls, `bus_gnt` drops one edge later and the prior state returns.
- R9: Priority in EXECUTE is `rst_req` over `sleep_stb`, and `sleep_stb` over `bus_req`.
- R10: `exc_start` is a one-cycle pulse that coincides with the first cycle of each EXCEPTION visit.
- R11: An `osc_wait` of 0 means no stabilization wait. An NMI out of STANDBY then reaches EXCEPTION at the first edge after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running reference clock |
| por_n | input | 1 | asynchronous block reset, active low |
| rst_req | input | 1 | power-on or manual reset request, level |
| sleep_stb | input | 1 | sleep instruction strobe from the core |
| stby_sel | input | 1 | selects standby (1) or sleep (0) on a sleep strobe |
| nmi | input | 1 | non-maskable interrupt |
| irq | input | 1 | any maskable interrupt |
| dma_aerr | input | 1 | DMA address error |
| bus_req | input | 1 | bus request from another master |
| exc_done | input | 1 | core has finished exception entry |
| osc_wait | input | CW | oscillator stabilization count in reference cycles |
| cpu_clk_en | output | 1 | core clock enable |
| per_clk_en | output | 1 | peripheral clock enable |
| osc_en | output | 1 | oscillator enable |
| bus_gnt | output | 1 | bus grant to the requester |
| exc_start | output | 1 | start exception processing pulse |
| state_o | output | 3 | current state code |

## Verification
A wrong state register shows on `state_o` and on the enable outputs in the first cycle after the edge that took the wrong branch. Each scenario therefore compares all of them directly after every edge. A stabilization counter that is off by one moves the STANDBY-to-EXCEPTION edge, and the cycle at which `cpu_clk_en` comes back, by exactly one cycle. The bench counts these edges exactly, so an early or late release is caught at once. A wake event that is ignored when it should act, or that acts when it should be ignored, shows as a mismatch on `state_o` at the next edge.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    PS_RESET  = 3'd0,
    PS_EXCEPT = 3'd1,
    PS_EXEC   = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_STBY   = 3'd4,
    PS_BUSREL = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/pwr_wake_decode.sv
module pwr_wake_decode (
  input  logic nmi,
  input  logic irq,
  input  logic dma_aerr,
  output logic sleep_wake,
  output logic stby_wake
);
  // light sleep accepts every interrupt source and DMA faults
  assign sleep_wake = nmi | irq | dma_aerr;
  // deep standby only the non-maskable source (reset handled in the FSM)
  assign stby_wake  = nmi;
endmodule

// File: rtl/pwr_osc_timer.sv
module pwr_osc_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy
);
  logic [CW-1:0] cnt_q;

  function automatic logic [CW-1:0] tick_down(input logic [CW-1:0] v);
    return v - {{(CW-1){1'b0}}, 1'b1};
  endfunction

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic last_tick;
  assign last_tick = busy && (cnt_q == ONE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      cnt_q <= load;
      busy  <= (load != '0);
    end else if (last_tick) begin
      cnt_q <= '0;
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= tick_down(cnt_q);
    end
  end

  a_r6_busy_nonzero: assert property (@(posedge clk) disable iff (!por_n)
    busy |-> (cnt_q != '0));
  a_r11_zero_load: assert property (@(posedge clk) disable iff (!por_n)
    (start && load == '0) |=> !busy);
  a_r7_count_moves: assert property (@(posedge clk) disable iff (!por_n)
    (busy && !start && !last_tick) |=> (busy && cnt_q == tick_down($past(cnt_q))));
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_req,
  input  logic       sleep_stb,
  input  logic       stby_sel,
  input  logic       bus_req,
  input  logic       exc_done,
  input  logic       sleep_wake,
  input  logic       stby_wake,
  input  logic       tmr_busy,
  output pwr_state_e state,
  output logic       wake_pend,
  output logic       tmr_start,
  output logic       exc_start
);
  pwr_state_e nxt, ret_q, ret_n;

  always_comb begin
    nxt       = state;
    ret_n     = ret_q;
    tmr_start = 1'b0;
    case (state)
      PS_RESET:  if (!rst_req && !tmr_busy) nxt = PS_EXCEPT;
      PS_EXCEPT: begin
        if (rst_req)       nxt = PS_RESET;
        else if (exc_done) nxt = PS_EXEC;
      end
      PS_EXEC: begin
        if (rst_req)        nxt = PS_RESET;
        else if (sleep_stb) nxt = stby_sel ? PS_STBY : PS_SLEEP;
        else if (bus_req) begin
          nxt   = PS_BUSREL;
          ret_n = PS_EXEC;
        end
      end
      PS_SLEEP: begin
        if (rst_req)         nxt = PS_RESET;
        else if (sleep_wake) nxt = PS_EXCEPT;
        else if (bus_req) begin
          nxt   = PS_BUSREL;
          ret_n = PS_SLEEP;
        end
      end
      PS_STBY: begin
        if (rst_req) begin
          nxt       = PS_RESET;
          tmr_start = 1'b1;
        end else if (wake_pend && !tmr_busy) begin
          nxt = PS_EXCEPT;
        end else if (stby_wake && !wake_pend) begin
          tmr_start = 1'b1;
        end
      end
      PS_BUSREL: begin
        if (rst_req)       nxt = PS_RESET;
        else if (!bus_req) nxt = ret_q;
      end
      default: nxt = PS_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state     <= PS_RESET;
      ret_q     <= PS_EXEC;
      wake_pend <= 1'b0;
      exc_start <= 1'b0;
    end else begin
      state     <= nxt;
      ret_q     <= ret_n;
      wake_pend <= (nxt == PS_STBY) && (wake_pend || stby_wake);
      exc_start <= (nxt == PS_EXCEPT) && (state != PS_EXCEPT);
    end
  end

  a_r4_sleep_wake: assert property (@(posedge clk) disable iff (!por_n)
    (state == PS_SLEEP && !rst_req && sleep_wake) |=> state == PS_EXCEPT);
  a_r5_stby_ignore: assert property (@(posedge clk) disable iff (!por_n)
    (state == PS_STBY && !rst_req && !stby_wake && !wake_pend) |=> state == PS_STBY);
  a_r7_hold_reset: assert property (@(posedge clk) disable iff (!por_n)
    (state == PS_RESET && tmr_busy) |=> state != PS_EXCEPT);
  a_r6_wait_osc: assert property (@(posedge clk) disable iff (!por_n)
    (state == PS_STBY && tmr_busy && !rst_req) |=> state == PS_STBY);
  a_r8_return: assert property (@(posedge clk) disable iff (!por_n)
    (state == PS_BUSREL && !bus_req && !rst_req) |=>
      (state == PS_EXEC || state == PS_SLEEP));
  a_r10_exc_pulse: assert property (@(posedge clk) disable iff (!por_n)
    exc_start |=> !exc_start);
  a_r10_exc_in_state: assert property (@(posedge clk) disable iff (!por_n)
    exc_start |-> state == PS_EXCEPT);
endmodule

// File: rtl/cpu_pwr_ctrl.sv
module cpu_pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_req,
  input  logic          sleep_stb,
  input  logic          stby_sel,
  input  logic          nmi,
  input  logic          irq,
  input  logic          dma_aerr,
  input  logic          bus_req,
  input  logic          exc_done,
  input  logic [CW-1:0] osc_wait,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic          osc_en,
  output logic          bus_gnt,
  output logic          exc_start,
  output logic [2:0]    state_o
);
  pwr_state_e state;
  logic sleep_wake, stby_wake, tmr_busy, tmr_start, wake_pend;

  pwr_wake_decode u_wake (
    .nmi(nmi), .irq(irq), .dma_aerr(dma_aerr),
    .sleep_wake(sleep_wake), .stby_wake(stby_wake)
  );

  pwr_osc_timer #(.CW(CW)) u_tmr (
    .clk(clk), .por_n(por_n), .start(tmr_start), .load(osc_wait), .busy(tmr_busy)
  );

  pwr_state_fsm u_fsm (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .sleep_stb(sleep_stb),
    .stby_sel(stby_sel), .bus_req(bus_req), .exc_done(exc_done),
    .sleep_wake(sleep_wake), .stby_wake(stby_wake), .tmr_busy(tmr_busy),
    .state(state), .wake_pend(wake_pend), .tmr_start(tmr_start),
    .exc_start(exc_start)
  );

  // clocks stay off while the oscillator is still settling
  assign cpu_clk_en = (state != PS_SLEEP) && (state != PS_STBY) && !tmr_busy;
  assign per_clk_en = (state != PS_STBY) && !tmr_busy;
  assign osc_en     = (state != PS_STBY) || wake_pend || tmr_busy;
  assign bus_gnt    = (state == PS_BUSREL);
  assign state_o    = state;

  a_r3_stby_no_grant: assert property (@(posedge clk) disable iff (!por_n)
    (state_o == 3'd4 && !rst_req) |=> !bus_gnt);
  a_r8_grant_drop: assert property (@(posedge clk) disable iff (!por_n)
    (bus_gnt && !bus_req) |=> !bus_gnt);
endmodule

// File: tb/sim_cpu_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_pwr_ctrl;
  localparam int CW = 16;
  logic clk = 1'b0;
  logic por_n, rst_req, sleep_stb, stby_sel, nmi, irq, dma_aerr, bus_req, exc_done;
  logic [CW-1:0] osc_wait;
  logic cpu_clk_en, per_clk_en, osc_en, bus_gnt, exc_start;
  logic [2:0] state_o;
  int n_vec = 0;
  int n_bad = 0;

  localparam int S_RST = 0, S_EXC = 1, S_EXE = 2, S_SLP = 3, S_STB = 4, S_BUS = 5;

  always #2 clk = ~clk;

  cpu_pwr_ctrl #(.CW(CW)) u0 (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .sleep_stb(sleep_stb),
    .stby_sel(stby_sel), .nmi(nmi), .irq(irq), .dma_aerr(dma_aerr),
    .bus_req(bus_req), .exc_done(exc_done), .osc_wait(osc_wait),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .bus_gnt(bus_gnt), .exc_start(exc_start), .state_o(state_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic enables(input string tag, input int c, input int p, input int o);
    chk({tag, " cpu_clk_en"}, int'(cpu_clk_en), c);
    chk({tag, " per_clk_en"}, int'(per_clk_en), p);
    chk({tag, " osc_en"}, int'(osc_en), o);
  endtask

  // from EXCEPTION, finish exception entry into EXECUTE
  task automatic finish_exc(input string tag);
    exc_done = 1'b1;
    step();
    exc_done = 1'b0;
    chk({tag, " to EXECUTE"}, int'(state_o), S_EXE);
  endtask

  task automatic t_reset();
    chk("R1 reset state", int'(state_o), S_RST);
    chk("R1 reset grant", int'(bus_gnt), 0);
    chk("R10 no pulse in reset", int'(exc_start), 0);
    rst_req = 1'b0;
    step();
    chk("R1 exit to EXCEPTION", int'(state_o), S_EXC);
    chk("R10 pulse first cycle", int'(exc_start), 1);
    step();
    chk("R1 wait exc_done", int'(state_o), S_EXC);
    chk("R10 pulse one cycle", int'(exc_start), 0);
    finish_exc("R1");
  endtask

  task automatic t_sleep_wake();
    for (int src = 0; src < 4; src++) begin
      sleep_stb = 1'b1; stby_sel = 1'b0;
      step();
      sleep_stb = 1'b0;
      chk("R2 enter SLEEP", int'(state_o), S_SLP);
      enables("R2 sleep", 0, 1, 1);
      step();
      chk("R2 stay SLEEP", int'(state_o), S_SLP);
      case (src)
        0: irq = 1'b1;
        1: nmi = 1'b1;
        2: dma_aerr = 1'b1;
        default: rst_req = 1'b1;
      endcase
      step();
      irq = 1'b0; nmi = 1'b0; dma_aerr = 1'b0; rst_req = 1'b0;
      if (src == 3) begin
        chk("R4 reset from SLEEP", int'(state_o), S_RST);
        step();
      end
      chk("R4 wake to EXCEPTION", int'(state_o), S_EXC);
      chk("R10 wake pulse", int'(exc_start), 1);
      finish_exc("R4");
    end
  endtask

  task automatic enter_stby(input string tag);
    sleep_stb = 1'b1; stby_sel = 1'b1;
    step();
    sleep_stb = 1'b0; stby_sel = 1'b0;
    chk({tag, " enter STANDBY"}, int'(state_o), S_STB);
    enables({tag, " standby"}, 0, 0, 0);
  endtask

  task automatic t_stby_ignore();
    enter_stby("R3");
    irq = 1'b1; dma_aerr = 1'b1; bus_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R5 stays STANDBY", int'(state_o), S_STB);
      chk("R5 no grant", int'(bus_gnt), 0);
      enables("R5 dark", 0, 0, 0);
    end
    irq = 1'b0; dma_aerr = 1'b0; bus_req = 1'b0;
  endtask

  // assumes the block is already in STANDBY
  task automatic t_stby_nmi(input int w);
    osc_wait = CW'(w);
    nmi = 1'b1;
    step();
    nmi = 1'b0;
    chk("R6 still STANDBY", int'(state_o), S_STB);
    enables("R6 osc restart", 0, 0, 1);
    for (int i = 0; i < w; i++) begin
      step();
      chk("R6 waiting", int'(state_o), S_STB);
      chk("R6 cpu off", int'(cpu_clk_en), 0);
    end
    step();
    chk(w == 0 ? "R11 zero wait EXCEPTION" : "R6 to EXCEPTION", int'(state_o), S_EXC);
    enables("R6 clocks back", 1, 1, 1);
    finish_exc("R6");
  endtask

  task automatic t_stby_reset(input int w);
    enter_stby("R7");
    osc_wait = CW'(w);
    rst_req = 1'b1;
    step();
    rst_req = 1'b0;
    chk("R7 to RESET", int'(state_o), S_RST);
    enables("R7 settling", 0, 0, 1);
    for (int i = 1; i < w; i++) begin
      step();
      chk("R7 held RESET", int'(state_o), S_RST);
      chk("R7 cpu off", int'(cpu_clk_en), 0);
    end
    step();
    chk("R7 count done", int'(state_o), S_RST);
    enables("R7 clocks back", 1, 1, 1);
    step();
    chk("R7 to EXCEPTION", int'(state_o), S_EXC);
    finish_exc("R7");
  endtask

  task automatic t_bus();
    bus_req = 1'b1;
    step();
    chk("R8 BUSREL from EXECUTE", int'(state_o), S_BUS);
    chk("R8 grant", int'(bus_gnt), 1);
    step();
    chk("R8 grant held", int'(bus_gnt), 1);
    bus_req = 1'b0;
    step();
    chk("R8 grant dropped", int'(bus_gnt), 0);
    chk("R8 back to EXECUTE", int'(state_o), S_EXE);
    // R9: sleep strobe beats a simultaneous bus request
    sleep_stb = 1'b1; bus_req = 1'b1;
    step();
    sleep_stb = 1'b0;
    chk("R9 sleep over bus", int'(state_o), S_SLP);
    step();
    chk("R8 BUSREL from SLEEP", int'(state_o), S_BUS);
    bus_req = 1'b0;
    step();
    chk("R8 back to SLEEP", int'(state_o), S_SLP);
    chk("R8 grant off", int'(bus_gnt), 0);
    irq = 1'b1;
    step();
    irq = 1'b0;
    finish_exc("R8");
    // R9: reset beats sleep and bus
    rst_req = 1'b1; sleep_stb = 1'b1; bus_req = 1'b1;
    step();
    rst_req = 1'b0; sleep_stb = 1'b0; bus_req = 1'b0;
    chk("R9 reset first", int'(state_o), S_RST);
    step();
    chk("R9 reset exits", int'(state_o), S_EXC);
    finish_exc("R9");
  endtask

  initial begin
    por_n = 1'b0; rst_req = 1'b1; sleep_stb = 1'b0; stby_sel = 1'b0;
    nmi = 1'b0; irq = 1'b0; dma_aerr = 1'b0; bus_req = 1'b0; exc_done = 1'b0;
    osc_wait = CW'(5);
    step(); step();
    chk("R1 state under por", int'(state_o), S_RST);
    por_n = 1'b1;
    step();
    t_reset();
    t_sleep_wake();
    t_stby_ignore();
    t_stby_nmi(5);
    enter_stby("R11");
    t_stby_nmi(0);
    t_stby_reset(7);
    t_bus();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule